// File: doc/BRIEF.md
# Matched Divider Pair for Two Clock Domains

This block produces two slow reference strobes, one from a core clock and one from a channel clock, for use by a phase comparator that expects equal frequencies on both inputs. The channel clock is not an input. The block makes it from a fast bus clock by a fixed division by four, and drives it out for use elsewhere.

Each domain has its own integer divisor: `m_div` for the core side and `n_div` for the channel side. System code picks the pair so that the core frequency over M equals the channel frequency over N. That makes the core-to-channel frequency ratio equal to M/N. For example, a core near 133 MHz with a 100 MHz channel clock pairs with M=4 and N=3, which gives roughly 33 MHz at both strobes.

Only the rising edges of the two strobes carry timing. Odd divisors give a high phase shorter than the low phase, so the falling edges of the two strobes do not in general line up. Each domain leaves reset through its own two-flop synchronizer. Each domain also raises a valid flag once its first complete divided period has ended.

Top module: `gear_div_pair`

## Requirements
- R1: While `rst_n` is low, all five outputs are low. Pulling `rst_n` low during operation clears them at once, without waiting for a clock edge.
- R2: `chan_clk_o` is `bus_clk` divided by four. It is high for two bus periods and low for two. Its first rise follows the 4th rising edge of `bus_clk` after `rst_n` rises.
- R3: Each domain's divider does nothing on the first two rising edges of its own clock after reset is released, and the output stays low through them. The 3rd edge is enabled edge k=1. For the channel domain, these edges are counted on `chan_clk_o`.
- R4: For an effective divisor D of 2 or more, the output is high after enabled edge k exactly when (k-1) mod D < floor(D/2). The output therefore rises at count zero and falls at count floor(D/2).
- R5: A divisor input of 0 behaves exactly like a divisor of 1.
- R6: With an effective divisor of 1, the output follows its source clock from enabled edge k=1 onward. It is high in the clock's high phase and low in its low phase.
- R7: The divisors are taken only while a domain's synchronized reset is asserted. Changes on `m_div` or `n_div` after that have no effect until the next reset.
- R8: A domain's valid flag is low until enabled edge k=D. It is high from that edge on until reset.
- R9: With the core period three times the bus period, M=4 and N=3, both strobes repeat every 12 bus periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| core_clk | input | 1 | Core-side clock |
| bus_clk | input | 1 | Fast bus clock; source of the channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_div | input | 4 | Core divisor M, unsigned, 0 means 1 |
| n_div | input | 4 | Channel divisor N, unsigned, 0 means 1 |
| chan_clk_o | output | 1 | Channel clock, `bus_clk` divided by four |
| core_div_o | output | 1 | Core clock divided by M |
| chan_div_o | output | 1 | Channel clock divided by N |
| core_vld_o | output | 1 | Core strobe has completed a full period |
| chan_vld_o | output | 1 | Channel strobe has completed a full period |

## Verification
The divider state is visible on the strobe ports within one divided period:

- **Count error.** A wrong wrap value or a count that slips moves the next rising edge of that strobe. This is seen no later than the D-th enabled edge.
- **Wrong divisor capture.** A divisor captured wrongly, or taken again after reset, changes the period from the next wrap on.
- **Synchronizer depth.** A synchronizer that is one stage short or one stage long shifts the first rise by one source clock edge.
- **Quarter-rate counter.** A fault here distorts the high and low times of `chan_clk_o` within four bus cycles. Every channel-domain edge then moves with it.

// File: rtl/gdp_pkg.sv
package gdp_pkg;
  // Number of divided domains and their slots in the per-domain vectors.
  localparam int unsigned NUM_DOMAINS = 2;
  localparam int unsigned DOM_CORE    = 0;
  localparam int unsigned DOM_CHAN    = 1;
  // Default depth of every reset synchronizer.
  localparam int unsigned RST_STAGES  = 2;
endpackage

// File: rtl/gdp_rst_sync.sv
module gdp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb shift_d = {shift_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= shift_d;
  end

  assign srst_n = shift_q[STAGES-1];
endmodule

// File: rtl/gdp_fixed_div.sv
module gdp_fixed_div #(
  parameter int unsigned RATIO_LOG2 = 2
) (
  input  logic clk,
  input  logic srst_n,
  output logic clk_o
);
  localparam int unsigned RATIO = 1 << RATIO_LOG2;
  localparam logic [RATIO_LOG2-1:0] RISE_AT = RATIO_LOG2'(RATIO / 2 - 1);
  localparam logic [RATIO_LOG2-1:0] STEP    = RATIO_LOG2'(1);

  logic [RATIO_LOG2-1:0] cnt_q;
  logic [RATIO_LOG2-1:0] cnt_d;

  always_comb cnt_d = cnt_q + STEP;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign clk_o = cnt_q[RATIO_LOG2-1];

  // R2
  quarter_rise_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(clk_o) |-> $past(cnt_q) == RISE_AT);
  // R2
  quarter_fall_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(clk_o) |-> $past(cnt_q) == '1);
endmodule

// File: rtl/gdp_int_div.sv
module gdp_int_div #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             div_o,
  output logic             vld_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] half, last;
  logic             out_q, out_d;
  logic             vld_q, vld_d;
  logic             gate_q;
  logic             pass, wrap;

  // Next-state logic
  always_comb begin
    div_d = (div_i == '0) ? ONE : div_i;
    half  = div_q >> 1;
    last  = div_q - ONE;
    wrap  = (cnt_q == last);
    cnt_d = wrap ? '0 : cnt_q + ONE;
    out_d = (cnt_q < half);
    vld_d = vld_q | wrap;
    pass  = (div_q == ONE);
  end

  // Divisor capture: enabled only while the domain reset is held
  always_ff @(posedge clk) begin
    if (!srst_n) div_q <= div_d;
  end

  // Counter, strobe and valid registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
      vld_q <= vld_d;
    end
  end

  // Low-phase enable for the divide-by-one path, glitch-free gating
  always_ff @(negedge clk or negedge srst_n) begin
    if (!srst_n) gate_q <= 1'b0;
    else         gate_q <= pass;
  end

  assign div_o = pass ? (clk & gate_q) : out_q;
  assign vld_o = vld_q;

  // R4
  rise_at_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(out_q) |-> $past(cnt_q) == '0);
  // R4
  fall_at_half_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(out_q) |-> $past(cnt_q) == $past(half));
  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_q < div_q);
  // R6
  pass_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    pass |-> !out_q);
  // R7
  div_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    srst_n |=> $stable(div_q));
  // R8
  vld_sticky_chk: assert property (@(posedge clk) disable iff (!srst_n)
    vld_q |=> vld_q);
endmodule

// File: rtl/gear_div_pair.sv
module gear_div_pair #(
  parameter int unsigned DIV_W       = 4,
  parameter int unsigned CHAN_LOG2   = 2,
  parameter int unsigned SYNC_STAGES = gdp_pkg::RST_STAGES
) (
  input  logic             core_clk,
  input  logic             bus_clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] m_div,
  input  logic [DIV_W-1:0] n_div,
  output logic             chan_clk_o,
  output logic             core_div_o,
  output logic             chan_div_o,
  output logic             core_vld_o,
  output logic             chan_vld_o
);
  localparam int unsigned NDOM = gdp_pkg::NUM_DOMAINS;

  logic             bus_srst_n;
  logic             chan_clk;
  logic [NDOM-1:0]  dom_clk;
  logic [NDOM-1:0]  dom_srst_n;
  logic [NDOM-1:0]  dom_div;
  logic [NDOM-1:0]  dom_vld;
  logic [DIV_W-1:0] dom_sel [NDOM];

  // Bus-side reset and the fixed quarter-rate channel clock
  gdp_rst_sync #(.STAGES(SYNC_STAGES)) u_bus_rst (
    .clk    (bus_clk),
    .arst_n (rst_n),
    .srst_n (bus_srst_n)
  );

  gdp_fixed_div #(.RATIO_LOG2(CHAN_LOG2)) u_chan_gen (
    .clk    (bus_clk),
    .srst_n (bus_srst_n),
    .clk_o  (chan_clk)
  );

  assign dom_clk[gdp_pkg::DOM_CORE] = core_clk;
  assign dom_clk[gdp_pkg::DOM_CHAN] = chan_clk;
  assign dom_sel[gdp_pkg::DOM_CORE] = m_div;
  assign dom_sel[gdp_pkg::DOM_CHAN] = n_div;

  // One synchronizer and one programmable divider per domain
  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    gdp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk    (dom_clk[g]),
      .arst_n (rst_n),
      .srst_n (dom_srst_n[g])
    );

    gdp_int_div #(.DIV_W(DIV_W)) u_div (
      .clk    (dom_clk[g]),
      .srst_n (dom_srst_n[g]),
      .div_i  (dom_sel[g]),
      .div_o  (dom_div[g]),
      .vld_o  (dom_vld[g])
    );
  end

  assign chan_clk_o = chan_clk;
  assign core_div_o = dom_div[gdp_pkg::DOM_CORE];
  assign chan_div_o = dom_div[gdp_pkg::DOM_CHAN];
  assign core_vld_o = dom_vld[gdp_pkg::DOM_CORE];
  assign chan_vld_o = dom_vld[gdp_pkg::DOM_CHAN];
endmodule

// File: tb/tb_gear_div_pair.sv
module tb_gear_div_pair;
  localparam int BUS_NS  = 10;
  localparam int CORE_NS = 30;
  localparam int NE      = 34;
  localparam int NVEC    = 6;

  typedef struct packed {
    logic [3:0] m;
    logic [3:0] n;
    logic [3:0] m_late;
    logic [3:0] n_late;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'd4,  4'd3, 4'd4, 4'd3},
    '{4'd2,  4'd2, 4'd7, 4'd9},
    '{4'd3,  4'd5, 4'd15, 4'd1},
    '{4'd0,  4'd1, 4'd6, 4'd2},
    '{4'd15, 4'd4, 4'd1, 4'd1},
    '{4'd5,  4'd0, 4'd2, 4'd3}
  };

  logic       core_clk, bus_clk, rst_n;
  logic [3:0] m_div, n_div;
  logic       chan_clk_o, core_div_o, chan_div_o, core_vld_o, chan_vld_o;
  int         n_chk, n_bad;
  bit         done;

  gear_div_pair dut (
    .core_clk   (core_clk),
    .bus_clk    (bus_clk),
    .rst_n      (rst_n),
    .m_div      (m_div),
    .n_div      (n_div),
    .chan_clk_o (chan_clk_o),
    .core_div_o (core_div_o),
    .chan_div_o (chan_div_o),
    .core_vld_o (core_vld_o),
    .chan_vld_o (chan_vld_o)
  );

  initial begin
    core_clk = 1'b0;
    forever #(CORE_NS / 2) core_clk = ~core_clk;
  end

  initial begin
    bus_clk = 1'b0;
    forever #(BUS_NS / 2) bus_clk = ~bus_clk;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    end
  endtask

  task automatic watch_core(input int d, input bit zero);
    for (int e = 1; e <= NE; e++) begin
      int    k;
      string tag;
      logic  exp;
      @(posedge core_clk);
      #5;
      k = e - 2;
      if (k < 1)       tag = "R3";
      else if (zero)   tag = "R5";
      else if (d == 1) tag = "R6";
      else if (e > 12) tag = "R7";
      else             tag = "R4";
      exp = (k >= 1) && ((d == 1) || (((k - 1) % d) < (d / 2)));
      chk({tag, " core"}, core_div_o, exp);
      chk("R8 core", core_vld_o, k >= d);
      if (d == 1 && k >= 1) begin
        #15;
        chk("R6 core low", core_div_o, 1'b0);
      end
    end
  endtask

  task automatic watch_chan(input int d, input bit zero);
    for (int e = 1; e <= NE; e++) begin
      int    k;
      string tag;
      logic  exp;
      @(posedge chan_clk_o);
      #2;
      k = e - 2;
      if (k < 1)       tag = "R3";
      else if (zero)   tag = "R5";
      else if (d == 1) tag = "R6";
      else if (e > 9)  tag = "R7";
      else             tag = "R4";
      exp = (k >= 1) && ((d == 1) || (((k - 1) % d) < (d / 2)));
      chk({tag, " chan"}, chan_div_o, exp);
      chk("R8 chan", chan_vld_o, k >= d);
      if (d == 1 && k >= 1) begin
        #20;
        chk("R6 chan low", chan_div_o, 1'b0);
      end
    end
  endtask

  task automatic hold_and_release(input logic [3:0] m, input logic [3:0] n);
    rst_n = 1'b0;
    m_div = m;
    n_div = n;
    #1;
    // R1: outputs cleared without a clock edge
    chk("R1 chan_clk", chan_clk_o, 1'b0);
    chk("R1 core_div", core_div_o, 1'b0);
    chk("R1 chan_div", chan_div_o, 1'b0);
    chk("R1 core_vld", core_vld_o, 1'b0);
    chk("R1 chan_vld", chan_vld_o, 1'b0);
    repeat (3) @(posedge core_clk);
    @(posedge core_clk);
    #7;
    rst_n = 1'b1;
  endtask

  task automatic run_vec(input vec_t vv);
    int dm, dn;
    dm = (vv.m == 4'd0) ? 1 : int'(vv.m);
    dn = (vv.n == 4'd0) ? 1 : int'(vv.n);
    hold_and_release(vv.m, vv.n);
    fork
      watch_core(dm, vv.m == 4'd0);
      watch_chan(dn, vv.n == 4'd0);
      begin
        #300;
        m_div = vv.m_late;
        n_div = vv.n_late;
      end
    join
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    m_div = 4'd4;
    n_div = 4'd3;

    for (int v = 0; v < NVEC; v++) run_vec(VECS[v]);

    // R2: quarter-rate channel clock, start latency and shape
    begin
      time t_rise, t_fall, t_next;
      hold_and_release(4'd4, 4'd3);
      for (int j = 1; j <= 4; j++) begin
        @(posedge bus_clk);
        #1;
        chk("R2 start", chan_clk_o, j == 4);
      end
      t_rise = $time - 1;
      @(negedge chan_clk_o);
      t_fall = $time;
      @(posedge chan_clk_o);
      t_next = $time;
      chk_int("R2 high time", t_fall - t_rise, 2 * BUS_NS);
      chk_int("R2 period", t_next - t_rise, 4 * BUS_NS);
    end

    // R9: matched divisors give equal strobe periods
    begin
      time c0, c1, h0, h1;
      wait (core_vld_o && chan_vld_o);
      @(posedge core_div_o);
      c0 = $time;
      @(posedge core_div_o);
      c1 = $time;
      @(posedge chan_div_o);
      h0 = $time;
      @(posedge chan_div_o);
      h1 = $time;
      chk_int("R9 core period", c1 - c0, 12 * BUS_NS);
      chk_int("R9 chan period", h1 - h0, 12 * BUS_NS);
    end

    // R1: reset pulled mid-run clears everything at once
    #13;
    rst_n = 1'b0;
    #1;
    chk("R1 mid chan_clk", chan_clk_o, 1'b0);
    chk("R1 mid core_div", core_div_o, 1'b0);
    chk("R1 mid chan_vld", chan_vld_o, 1'b0);

    report();
    $finish;
  end

  initial begin
    #(CORE_NS * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired at %0t", $time);
    report();
    $finish;
  end
endmodule